// File: doc/BRIEF.md
# Single-Chamber Pacing Timing Controller

This block times ventricular stimulation from a handful of programmed parameters. A millisecond strobe drives an escape counter. When the counter runs out, the block issues a pace pulse. The pulse length is counted on a separate, finer sub-tick. Each pace or accepted intrinsic beat opens a refractory window. While that window is open the sense path is blanked, so the block's own stimulus and the waves that follow it are not taken for heartbeats.

Two modes exist. In fixed-rate mode the block paces at the programmed rate and never looks at the sense comparator. In demand mode a beat sensed outside refractory cancels the pending pace and restarts the escape timing from that beat. A magnet input forces fixed-rate pacing at a rate that depends on a battery-replacement flag. When a high rate is programmed, an optional automatic switch shortens refractory to a fixed value. All parameter changes are latched only at the start of a pacing cycle, so a cycle in progress keeps its timing.

Top module: `pace_timing_ctrl`

## Requirements
- R1: The escape interval, in ms ticks, is the integer quotient of 60000 by the effective rate in bpm (80 bpm gives 750, 150 bpm gives 400, 32 bpm gives 1875). In fixed-rate mode, consecutive pace pulses start exactly that many ms ticks apart.
- R2: pace_o rises on the clock after the ms tick that ends the interval. It stays high for pw_i sub-ticks, where pw_i counts 10 µs sub-tick units.
- R3: The refractory length is 200 + 15·refr_code_i ms, with refr_code_i taking values 0 to 20. refr_o rises on the same clock as pace_o (or on the clock after an accepted sense) and falls on the clock after the ms tick that completes the length.
- R4: When auto_refr_i is 1 and the effective rate exceeds 120 bpm, the refractory length is 250 ms. At exactly 120 bpm, the programmed length applies.
- R5: In demand mode (mode_i = 1), sense_i high at an ms tick outside refractory is an accepted sense. It produces no pace, starts refractory on the next clock, and schedules the next pace one full interval after that tick.
- R6: In demand mode, sense_i is ignored while refr_o is high. sense_en_o is low during refractory and high outside it.
- R7: In fixed-rate mode (mode_i = 0), sense_i has no effect on pacing and sense_en_o stays low.
- R8: With magnet_i high, the block paces in fixed-rate mode and ignores sense. The rate is 96 bpm (625 ms) when eri_i is 0 and 84 bpm (714 ms) when eri_i is 1.
- R9: Changes to the rate, mode, refractory, pulse width and magnet inputs take effect only at the next cycle start (a pace or an accepted sense).
- R10: During reset, pace_o, refr_o and sense_en_o are low. The first cycle begins on the first clock after reset, using the inputs present at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-clock strobe every millisecond |
| sub_tick_i | input | 1 | One-clock strobe every 10 µs for pulse timing |
| sense_i | input | 1 | Sense comparator output |
| mode_i | input | 1 | 0 = fixed-rate, 1 = demand |
| rate_i | input | 8 | Programmed rate in bpm |
| refr_code_i | input | 5 | Refractory step code |
| auto_refr_i | input | 1 | Enables the automatic refractory switch |
| pw_i | input | 8 | Pulse width in sub-ticks |
| magnet_i | input | 1 | Magnet override |
| eri_i | input | 1 | Battery-replacement indicator |
| pace_o | output | 1 | Pace stimulus |
| refr_o | output | 1 | Refractory window active |
| sense_en_o | output | 1 | Sense path enabled |

## Verification
A pace, and the refractory that opens with it, appears one clock after the ms tick that ends the interval. An accepted sense acts on the same tick at which the block samples sense_i, and its refractory shows one clock later. The pulse ends one clock after its last sub-tick. The bench drives both strobes itself, counts the ms ticks it has issued, and reads every output at the falling clock edge. Each interval and refractory length is therefore a difference of tick counts taken at those samples, and each pulse width is a count of high samples. Sense is raised one tick ahead of the target tick and dropped right after it, so that exactly one tick carries it.

// File: rtl/pace_pkg.sv
package pace_pkg;
  typedef enum logic {
    MODE_ASYNC   = 1'b0,
    MODE_INHIBIT = 1'b1
  } pace_mode_e;
endpackage

// File: rtl/pace_rate_calc.sv
module pace_rate_calc #(
  parameter int RATE_W        = 8,
  parameter int INT_W         = 12,
  parameter int REFR_W        = 9,
  parameter int CODE_W        = 5,
  parameter int MS_PER_MIN    = 60000,
  parameter int MIN_RATE      = 32,
  parameter int MAG_BOL_BPM   = 96,
  parameter int MAG_ERI_BPM   = 84,
  parameter int AUTO_RATE_BPM = 120,
  parameter int AUTO_REFR_MS  = 250,
  parameter int REFR_BASE_MS  = 200,
  parameter int REFR_STEP_MS  = 15,
  parameter int REFR_MAX_CODE = 20
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [CODE_W-1:0] refr_code_i,
  input  logic              auto_refr_i,
  input  logic              magnet_i,
  input  logic              eri_i,
  output logic [INT_W-1:0]  interval_o,
  output logic [REFR_W-1:0] refr_len_o
);
  logic [RATE_W-1:0] rate_eff;
  logic [CODE_W-1:0] code_c;

  always_comb begin
    if (magnet_i)                        rate_eff = eri_i ? RATE_W'(MAG_ERI_BPM) : RATE_W'(MAG_BOL_BPM);
    else if (rate_i < RATE_W'(MIN_RATE)) rate_eff = RATE_W'(MIN_RATE);
    else                                 rate_eff = rate_i;

    code_c = (refr_code_i > CODE_W'(REFR_MAX_CODE)) ? CODE_W'(REFR_MAX_CODE) : refr_code_i;

    interval_o = INT_W'(MS_PER_MIN / int'(rate_eff));

    if (auto_refr_i && (rate_eff > RATE_W'(AUTO_RATE_BPM)))
      refr_len_o = REFR_W'(AUTO_REFR_MS);
    else
      refr_len_o = REFR_W'(REFR_BASE_MS + REFR_STEP_MS * int'(code_c));
  end
endmodule

// File: rtl/pace_pulse_gen.sv
module pace_pulse_gen #(
  parameter int PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            sub_tick_i,
  input  logic [PW_W-1:0] pw_i,
  output logic            pulse_o
);
  logic [PW_W-1:0] pw_q, cnt_q;
  logic            on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
      pw_q  <= PW_W'(1);
    end else if (start_i) begin
      on_q  <= 1'b1;
      cnt_q <= '0;
      pw_q  <= (pw_i == '0) ? PW_W'(1) : pw_i;
    end else if (on_q && sub_tick_i) begin
      if (cnt_q + PW_W'(1) == pw_q) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + PW_W'(1);
      end
    end
  end

  assign pulse_o = on_q;

  AST_PULSE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |-> (cnt_q < pw_q)); // R2
endmodule

// File: rtl/pace_refr_timer.sv
module pace_refr_timer #(
  parameter int REFR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ms_tick_i,
  input  logic [REFR_W-1:0] len_i,
  output logic              active_o
);
  logic [REFR_W-1:0] len_q, cnt_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      len_q <= REFR_W'(1);
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      len_q <= (len_i == '0) ? REFR_W'(1) : len_i;
    end else if (act_q && ms_tick_i) begin
      if (cnt_q + REFR_W'(1) == len_q) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + REFR_W'(1);
      end
    end
  end

  assign active_o = act_q;

  AST_REFR_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q < len_q)); // R3
endmodule

// File: rtl/pace_timing_ctrl.sv
module pace_timing_ctrl
  import pace_pkg::*;
#(
  parameter int RATE_W        = 8,
  parameter int INT_W         = 12,
  parameter int REFR_W        = 9,
  parameter int CODE_W        = 5,
  parameter int PW_W          = 8,
  parameter int MS_PER_MIN    = 60000,
  parameter int MIN_RATE      = 32,
  parameter int MAG_BOL_BPM   = 96,
  parameter int MAG_ERI_BPM   = 84,
  parameter int AUTO_RATE_BPM = 120,
  parameter int AUTO_REFR_MS  = 250,
  parameter int REFR_BASE_MS  = 200,
  parameter int REFR_STEP_MS  = 15,
  parameter int REFR_MAX_CODE = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              sub_tick_i,
  input  logic              sense_i,
  input  logic              mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [CODE_W-1:0] refr_code_i,
  input  logic              auto_refr_i,
  input  logic [PW_W-1:0]   pw_i,
  input  logic              magnet_i,
  input  logic              eri_i,
  output logic              pace_o,
  output logic              refr_o,
  output logic              sense_en_o
);
  localparam logic [INT_W-1:0] RST_INTERVAL = INT_W'(MS_PER_MIN / MIN_RATE);

  logic [INT_W-1:0]  interval_nxt, interval_q, cnt_q;
  logic [REFR_W-1:0] refr_len_nxt;
  logic              load_q, sense_hit, pace_fire, cyc_start, refr_act;
  pace_mode_e        mode_q;

  pace_rate_calc #(
    .RATE_W(RATE_W), .INT_W(INT_W), .REFR_W(REFR_W), .CODE_W(CODE_W),
    .MS_PER_MIN(MS_PER_MIN), .MIN_RATE(MIN_RATE),
    .MAG_BOL_BPM(MAG_BOL_BPM), .MAG_ERI_BPM(MAG_ERI_BPM),
    .AUTO_RATE_BPM(AUTO_RATE_BPM), .AUTO_REFR_MS(AUTO_REFR_MS),
    .REFR_BASE_MS(REFR_BASE_MS), .REFR_STEP_MS(REFR_STEP_MS),
    .REFR_MAX_CODE(REFR_MAX_CODE)
  ) u_rate_calc (
    .rate_i      (rate_i),
    .refr_code_i (refr_code_i),
    .auto_refr_i (auto_refr_i),
    .magnet_i    (magnet_i),
    .eri_i       (eri_i),
    .interval_o  (interval_nxt),
    .refr_len_o  (refr_len_nxt)
  );

  // accepted sense wins over a pace due on the same tick
  assign sense_hit = ms_tick_i && !load_q && (mode_q == MODE_INHIBIT) && sense_i && !refr_act;
  assign pace_fire = ms_tick_i && !load_q && !sense_hit && (cnt_q + INT_W'(1) == interval_q);
  assign cyc_start = load_q || pace_fire || sense_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q     <= 1'b1;
      mode_q     <= MODE_ASYNC;
      interval_q <= RST_INTERVAL;
      cnt_q      <= '0;
    end else begin
      load_q <= 1'b0;
      if (cyc_start) begin
        cnt_q      <= '0;
        interval_q <= interval_nxt;
        mode_q     <= (mode_i && !magnet_i) ? MODE_INHIBIT : MODE_ASYNC;
      end else if (ms_tick_i) begin
        cnt_q <= cnt_q + INT_W'(1);
      end
    end
  end

  pace_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (pace_fire),
    .sub_tick_i (sub_tick_i),
    .pw_i       (pw_i),
    .pulse_o    (pace_o)
  );

  pace_refr_timer #(.REFR_W(REFR_W)) u_refr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (pace_fire || sense_hit),
    .ms_tick_i (ms_tick_i),
    .len_i     (refr_len_nxt),
    .active_o  (refr_act)
  );

  assign refr_o     = refr_act;
  assign sense_en_o = (mode_q == MODE_INHIBIT) && !refr_act;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < interval_q); // R1
  AST_REFR_WITH_PACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pace_o) |-> refr_o); // R3
  AST_SENSE_BLOCKS_PACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_tick_i && sense_i && sense_en_o) |=> !$rose(pace_o)); // R5
endmodule

// File: tb/pace_timing_ctrl_tb_top.sv
module pace_timing_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       sense = 1'b0, mode = 1'b0, auto_refr = 1'b0, magnet = 1'b0, eri = 1'b0;
  logic [7:0] rate = 8'd80;
  logic [4:0] refr_code = 5'd3;
  logic [7:0] pw = 8'd45;
  logic       pace, refr, sense_en;
  int         checks = 0, errors = 0, ms_count = 0, div = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div     <= (div == 3) ? 0 : div + 1;
    ms_tick <= (div == 3);
  end
  always @(posedge clk) if (ms_tick) ms_count <= ms_count + 1;

  pace_timing_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(ms_tick), .sub_tick_i(1'b1),
    .sense_i(sense), .mode_i(mode), .rate_i(rate), .refr_code_i(refr_code),
    .auto_refr_i(auto_refr), .pw_i(pw), .magnet_i(magnet), .eri_i(eri),
    .pace_o(pace), .refr_o(refr), .sense_en_o(sense_en)
  );

  // rate, refr code, auto, pw, expected interval, expected refractory, expected width
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{80,  3, 0, 45,  750,  245, 45},
    '{120, 0, 1, 7,   500,  200, 7},
    '{150, 10, 1, 150, 400, 250, 150},
    '{150, 10, 0, 20,  400, 350, 20},
    '{32,  20, 0, 100, 1875, 500, 100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int m);
    do @(negedge clk); while (pace);
    do @(negedge clk); while (!pace);
    m = ms_count;
  endtask

  task automatic wait_ms(input int target);
    while (ms_count != target) @(negedge clk);
  endtask

  task automatic measure(input int m0, output int ivl, output int rlen, output int pwc);
    bit pw_done = 1'b0;
    bit r_done  = 1'b0;
    pwc  = 1;
    rlen = -1;
    do begin
      @(negedge clk);
      if (!pw_done) begin
        if (pace) pwc++;
        else pw_done = 1'b1;
      end
      if (!r_done && !refr) begin
        r_done = 1'b1;
        rlen   = ms_count - m0;
      end
    end while (!(pw_done && pace));
    ivl = ms_count - m0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int m0, m1, m2, ivl, rl, pwc;
    mode = 1'b1;
    repeat (3) @(negedge clk);
    check(!pace && !refr && !sense_en, "R10 outputs low in reset", {29'd0, pace, refr, sense_en}, 0);
    mode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      rate = 8'(VEC[i][0]); refr_code = 5'(VEC[i][1]);
      auto_refr = VEC[i][2][0]; pw = 8'(VEC[i][3]);
      wait_rise(m0);
      check(refr == 1'b1, "R3 refractory opens with pace", int'(refr), 1);
      measure(m0, ivl, rl, pwc);
      check(ivl == VEC[i][4], "R1 interval", ivl, VEC[i][4]);
      check(rl == VEC[i][5], "R3/R4 refractory length", rl, VEC[i][5]);
      check(pwc == VEC[i][6], "R2 pulse width", pwc, VEC[i][6]);
    end

    // demand mode: 80 bpm, 200 ms refractory
    mode = 1'b1; rate = 8'd80; refr_code = 5'd0; auto_refr = 1'b0; pw = 8'd10;
    wait_rise(m0);
    check(sense_en == 1'b0, "R6 sense disabled in refractory", int'(sense_en), 0);
    wait_ms(m0 + 99); sense = 1'b1;
    wait_ms(m0 + 100); sense = 1'b0;
    wait_rise(m1);
    check(m1 - m0 == 750, "R6 sense in refractory ignored", m1 - m0, 750);
    wait_ms(m1 + 200);
    check(sense_en == 1'b1, "R6 sense enabled after refractory", int'(sense_en), 1);
    wait_ms(m1 + 399); sense = 1'b1;
    wait_ms(m1 + 400); sense = 1'b0;
    check(refr == 1'b1 && pace == 1'b0, "R5 accepted sense opens refractory", {30'd0, refr, pace}, 2);
    wait_rise(m2);
    check(m2 - m1 == 1150, "R5 escape restarted at sense", m2 - m1, 1150);

    // fixed-rate mode with sense held high
    mode = 1'b0; sense = 1'b1;
    wait_rise(m0);
    wait_rise(m0);
    check(sense_en == 1'b0, "R7 sense disabled in fixed-rate", int'(sense_en), 0);
    wait_rise(m1);
    check(m1 - m0 == 750, "R7 sense ignored", m1 - m0, 750);

    // magnet override while programmed to demand mode, sense held high
    mode = 1'b1; magnet = 1'b1; eri = 1'b0;
    wait_rise(m0);
    wait_rise(m0);
    wait_rise(m1);
    check(m1 - m0 == 625, "R8 magnet rate at beginning of life", m1 - m0, 625);
    check(sense_en == 1'b0, "R8 magnet forces fixed-rate", int'(sense_en), 0);
    eri = 1'b1;
    wait_rise(m1);
    wait_rise(m2);
    check(m2 - m1 == 714, "R8 magnet rate with replacement flag", m2 - m1, 714);
    magnet = 1'b0; eri = 1'b0; sense = 1'b0;

    // mid-cycle parameter change
    mode = 1'b0; rate = 8'd80;
    wait_rise(m0);
    wait_rise(m0);
    wait_ms(m0 + 100); rate = 8'd120;
    wait_rise(m1);
    check(m1 - m0 == 750, "R9 cycle in progress keeps interval", m1 - m0, 750);
    wait_rise(m2);
    check(m2 - m1 == 500, "R9 new rate at next cycle", m2 - m1, 500);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule